// File: doc/BRIEF.md
# Boot Wake-Up Handshake Detector

This block sits on the target side of a serial byte stream, ahead of the framed packet layer. While hunting, it watches each valid incoming byte for one of two wake-up patterns from a host:

- a run of frame-tag bytes (0x7E);
- exactly four consecutive 0xAE bytes.

When a pattern completes, the block stops looking at the input. It then plays back a fixed reply string through a valid/ready byte output. The legacy wake-up gets a tilde-framed identification string. The modern wake-up gets a version string.

After the last reply byte has been accepted, the block raises a connected flag and holds it until reset. The flag hands the link over to the packet layer. A mode output reports which of the two wake-ups was recognised. Both reply strings, the minimum run length and the modern sequence length are parameters.

Top module: `boot_hs_detect`

## Requirements
- R1: After reset, `tx_valid_o` is 0, `connected_o` is 0 and `mode_o` is 0 (none).
- R2: `LEG_MIN` (default 3) consecutive valid bytes of 0x7E set `mode_o` to 1 (legacy) on the clock edge that takes the last of them. On the same edge, `tx_valid_o` rises.
- R3: Any valid byte other than 0x7E clears the legacy run, so 7E 7E 00 7E 7E does not trigger.
- R4: `MOD_LEN` (default 4) consecutive valid bytes of 0xAE set `mode_o` to 2 (modern) and start the reply on the edge that takes the last byte.
- R5: A valid byte other than 0xAE inside the modern sequence restarts it, so AE AE AE 7E AE AE AE does not trigger.
- R6: The legacy reply is the ASCII string "~HSID1~", sent first character first. One byte moves per cycle with `tx_valid_o` and `tx_ready_i` both high. While ready is low, `tx_valid_o` and `tx_data_o` hold.
- R7: The modern reply is the ASCII string "VER2.1", sent first character first under the same handshake.
- R8: Bytes received while a reply is in progress change neither the reply bytes nor `mode_o`.
- R9: When the last reply byte is accepted, `connected_o` rises and `tx_valid_o` falls. Both stay that way until reset, whatever arrives on the input, including further wake-up patterns.
- R10: Cycles with `rx_valid_i` low neither count toward nor break a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Incoming byte is valid this cycle |
| rx_data_i | input | 8 | Incoming byte |
| tx_valid_o | output | 1 | Reply byte available |
| tx_data_o | output | 8 | Reply byte |
| tx_ready_i | input | 1 | Sink accepts the reply byte |
| mode_o | output | 2 | 0 none, 1 legacy, 2 modern |
| connected_o | output | 1 | Handshake finished, packet layer owns the link |

## Verification
Two functions can fall in the same cycle:

- the acceptance of the final reply byte, which moves the block to connected;
- the arrival of a host byte, which could restart detection if the block were still hunting.

The bench keeps streaming wake-up bytes throughout each reply while the sink's ready toggles pseudo-randomly, so arrivals land on the final acceptance and on stalled cycles alike. A scoreboard judges the result. It demands that exactly the expected reply string emerges, with no extra byte afterwards, and that mode and connected stay unchanged.

// File: rtl/boot_hs_pkg.sv
package boot_hs_pkg;
  typedef enum logic [1:0] {
    HS_NONE   = 2'd0,
    HS_LEGACY = 2'd1,
    HS_MODERN = 2'd2
  } hs_mode_e;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_SEND,
    ST_LINKED
  } hs_state_e;

  localparam logic [7:0] TAG_BYTE  = 8'h7E;
  localparam logic [7:0] HOST_BYTE = 8'hAE;
endpackage

// File: rtl/hs_run_detect.sv
// Counts consecutive enabled bytes equal to MATCH; hit_o when the RUN-th arrives.
module hs_run_detect #(
  parameter logic [7:0] MATCH = 8'h7E,
  parameter int unsigned RUN  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [7:0] data_i,
  output logic       hit_o
);
  localparam int unsigned CW = $clog2(RUN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN - 1);

  logic [CW-1:0] cnt_q;
  logic          match;

  assign match = (data_i == MATCH);
  assign hit_o = en_i && match && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (!match || hit_o) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hs_reply_tx.sv
// Plays one of two constant strings out of a valid/ready byte port.
module hs_reply_tx #(
  parameter int unsigned LEG_LEN = 7,
  parameter logic [8*LEG_LEN-1:0] LEG_STR = "~HSID1~",
  parameter int unsigned MOD_LEN = 6,
  parameter logic [8*MOD_LEN-1:0] MOD_STR = "VER2.1"
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       sel_mod_i,
  input  logic       tx_ready_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  output logic       done_o
);
  localparam int unsigned MAX_LEN = (LEG_LEN > MOD_LEN) ? LEG_LEN : MOD_LEN;
  localparam int unsigned IW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam logic [IW-1:0] LEG_LAST = IW'(LEG_LEN - 1);
  localparam logic [IW-1:0] MOD_LAST = IW'(MOD_LEN - 1);

  logic [7:0] leg_rom [MAX_LEN];
  logic [7:0] mod_rom [MAX_LEN];

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_rom
    if (g < LEG_LEN) begin : g_leg
      assign leg_rom[g] = LEG_STR[8*(LEG_LEN-1-g) +: 8];
    end else begin : g_leg_pad
      assign leg_rom[g] = 8'h00;
    end
    if (g < MOD_LEN) begin : g_mod
      assign mod_rom[g] = MOD_STR[8*(MOD_LEN-1-g) +: 8];
    end else begin : g_mod_pad
      assign mod_rom[g] = 8'h00;
    end
  end

  logic          busy_q, sel_q;
  logic [IW-1:0] idx_q;
  logic          fire, last;

  assign fire       = busy_q && tx_ready_i;
  assign last       = (idx_q == (sel_q ? MOD_LAST : LEG_LAST));
  assign done_o     = fire && last;
  assign tx_valid_o = busy_q;
  assign tx_data_o  = sel_q ? mod_rom[idx_q] : leg_rom[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sel_q  <= 1'b0;
      idx_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      sel_q  <= sel_mod_i;
      idx_q  <= '0;
    end else if (fire) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/boot_hs_detect.sv
module boot_hs_detect
  import boot_hs_pkg::*;
#(
  parameter int unsigned LEG_MIN = 3,
  parameter int unsigned MOD_LEN = 4,
  parameter int unsigned LEG_REPLY_LEN = 7,
  parameter logic [8*LEG_REPLY_LEN-1:0] LEG_REPLY = "~HSID1~",
  parameter int unsigned MOD_REPLY_LEN = 6,
  parameter logic [8*MOD_REPLY_LEN-1:0] MOD_REPLY = "VER2.1"
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  input  logic       tx_ready_i,
  output logic [1:0] mode_o,
  output logic       connected_o
);
  hs_state_e state_q;
  hs_mode_e  mode_q;
  logic      hunt_en, leg_hit, mod_hit, start, done;

  // input is only looked at while hunting
  assign hunt_en = rx_valid_i && (state_q == ST_HUNT);
  assign start   = leg_hit || mod_hit;

  hs_run_detect #(.MATCH(TAG_BYTE), .RUN(LEG_MIN)) u_leg_det (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(hunt_en),
    .data_i(rx_data_i), .hit_o(leg_hit)
  );

  hs_run_detect #(.MATCH(HOST_BYTE), .RUN(MOD_LEN)) u_mod_det (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(hunt_en),
    .data_i(rx_data_i), .hit_o(mod_hit)
  );

  hs_reply_tx #(
    .LEG_LEN(LEG_REPLY_LEN), .LEG_STR(LEG_REPLY),
    .MOD_LEN(MOD_REPLY_LEN), .MOD_STR(MOD_REPLY)
  ) u_reply (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .sel_mod_i (mod_hit),
    .tx_ready_i(tx_ready_i),
    .tx_valid_o(tx_valid_o),
    .tx_data_o (tx_data_o),
    .done_o    (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      mode_q  <= HS_NONE;
    end else begin
      unique case (state_q)
        ST_HUNT: if (start) begin
          state_q <= ST_SEND;
          mode_q  <= mod_hit ? HS_MODERN : HS_LEGACY;
        end
        ST_SEND: if (done) state_q <= ST_LINKED;
        ST_LINKED: state_q <= ST_LINKED;
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  assign mode_o      = mode_q;
  assign connected_o = (state_q == ST_LINKED);
endmodule

// File: rtl/boot_hs_detect_chk.sv
module boot_hs_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_valid_o,
  input logic [7:0] tx_data_o,
  input logic       tx_ready_i,
  input logic [1:0] mode_o,
  input logic       connected_o
);
  // R6
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  // R9
  linked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    connected_o |=> connected_o && $stable(mode_o));

  // R9
  linked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    connected_o |-> !tx_valid_o);

  // R8
  mode_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd0) |=> $stable(mode_o));

  // R2
  reply_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> (mode_o == 2'd1 || mode_o == 2'd2));

  // R1
  mode_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);
endmodule

bind boot_hs_detect boot_hs_detect_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .tx_ready_i (tx_ready_i),
  .mode_o     (mode_o),
  .connected_o(connected_o)
);

// File: tb/boot_hs_detect_tb.sv
`timescale 1ns/1ps
module boot_hs_detect_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       tx_valid, connected;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b1;
  logic [1:0] mode;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  int unsigned n_out = 0;
  bit          rdy_rand = 1'b0;
  string       cur_req = "R6";
  logic [7:0]  exp_q [$];

  always #2.5 clk = ~clk;

  boot_hs_detect u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .mode_o(mode), .connected_o(connected)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: sets ready for the coming edge, then scores any byte it will take
  always @(negedge clk) begin
    tx_ready = rdy_rand ? (($urandom % 3) != 0) : 1'b1;
    if (rst_n && tx_valid && tx_ready) begin
      n_out++;
      if (exp_q.size() == 0) begin
        check(cur_req, {24'h0, tx_data}, 32'hFFFF_FFFF);
      end else begin
        check(cur_req, {24'h0, tx_data}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic rx_byte(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
  endtask

  task automatic rx_idle(int n);
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic expect_str(string s);
    for (int i = 0; i < s.len(); i++) exp_q.push_back(s[i]);
  endtask

  task automatic do_reset();
    rx_valid = 1'b0;
    rst_n = 1'b0;
    exp_q.delete();
    n_out = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // keeps throwing wake-up bytes at the block until it reports connected
  task automatic flood_until_linked(string req);
    int guard = 0;
    while (!connected && guard < 400) begin
      rx_byte((guard % 3 == 0) ? 8'hAE : 8'h7E);
      guard++;
    end
    rx_idle(2);
    check(req, {31'h0, connected}, 32'h1);
  endtask

  task automatic after_link(string req, logic [1:0] exp_mode);
    for (int i = 0; i < 6; i++) rx_byte(8'h7E);
    for (int i = 0; i < 4; i++) rx_byte(8'hAE);
    rx_idle(4);
    check(req, {31'h0, tx_valid}, 32'h0);
    check(req, {31'h0, connected}, 32'h1);
    check(req, {30'h0, mode}, {30'h0, exp_mode});
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1", {31'h0, tx_valid}, 32'h0);
    check("R1", {31'h0, connected}, 32'h0);
    check("R1", {30'h0, mode}, 32'h0);

    // R3 broken legacy run must not trigger
    rx_byte(8'h7E); rx_byte(8'h7E); rx_byte(8'h00);
    rx_byte(8'h7E); rx_byte(8'h7E);
    rx_idle(3);
    check("R3", {30'h0, mode}, 32'h0);
    check("R3", {31'h0, tx_valid}, 32'h0);

    // R2 third consecutive tag completes legacy wake-up
    cur_req = "R6";
    expect_str("~HSID1~");
    rdy_rand = 1'b1;
    rx_byte(8'h7E);
    @(negedge clk);
    rx_valid = 1'b0;
    check("R2", {30'h0, mode}, 32'h1);
    // R8 bytes during reply ignored; R9 link follows the last byte
    cur_req = "R8";
    flood_until_linked("R9");
    check("R6", exp_q.size(), 32'h0);
    check("R6", n_out, 32'd7);
    after_link("R9", 2'd1);

    // R5 broken modern sequence must not trigger
    do_reset();
    rdy_rand = 1'b0;
    rx_byte(8'hAE); rx_byte(8'hAE); rx_byte(8'hAE); rx_byte(8'h7E);
    rx_byte(8'hAE); rx_byte(8'hAE); rx_byte(8'hAE);
    rx_idle(3);
    check("R5", {30'h0, mode}, 32'h0);
    check("R5", {31'h0, tx_valid}, 32'h0);

    // R10 idle gap keeps the run; R4 fourth AE triggers modern
    cur_req = "R7";
    expect_str("VER2.1");
    rx_byte(8'hAE);
    @(negedge clk);
    rx_valid = 1'b0;
    check("R4", {30'h0, mode}, 32'h2);
    check("R10", {31'h0, tx_valid}, 32'h1);
    rdy_rand = 1'b1;
    flood_until_linked("R9");
    check("R7", exp_q.size(), 32'h0);
    check("R7", n_out, 32'd6);
    after_link("R9", 2'd2);

    // R10 legacy run spread over idle cycles
    do_reset();
    rdy_rand = 1'b0;
    cur_req = "R10";
    expect_str("~HSID1~");
    rx_byte(8'h7E); rx_idle(3);
    rx_byte(8'h7E); rx_idle(2);
    rx_byte(8'h7E);
    @(negedge clk);
    rx_valid = 1'b0;
    check("R10", {30'h0, mode}, 32'h1);
    repeat (12) @(negedge clk);
    check("R10", {31'h0, connected}, 32'h1);
    check("R6", exp_q.size(), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule